// File: doc/BRIEF.md
# E3 Overhead Event Interrupt Register

This block sits behind an E3 receive framer that has already located each frame and extracted its overhead. Once per frame, on a boundary strobe, it examines the captured overhead: the two framing bytes, the parity-check verdict, the far-end error and failure indications, the payload type field and the trail trace byte. It also watches a pulse from the data-link message receiver in every cycle. Each defined condition raises one bit of an 8-bit status word.

Status bits are sticky and cleared by a read strobe, so software sees every event that happened since its last read. Two bits compare across frames rather than flag a level: the payload type bit reports a change from the previous frame, and the far-end failure bit reports both the start and the end of the failure condition. A single interrupt line combines the status bits with a per-bit enable mask; the mask gates only the line, never the recording of events.

Top module: `e3ovh_irq_reg`

## Requirements
- R1: After reset, `status` is 8'h00 and `irq` is 0.
- R2: Bit 6 of `status` sets when a frame strobe arrives with `tr_byte[7]` at 1 (start of a trace message); a trace byte with bit 7 at 0 sets nothing.
- R3: Bit 5 of `status` sets in the cycle after `lapd_done` is high, whether or not a frame strobe is present.
- R4: Bit 4 of `status` sets when a frame strobe arrives with `febe_bit` at 1.
- R5: The far-end failure condition holds in a frame when all bits of `x_bits` are 0. Bit 3 of `status` sets in a frame whose condition differs from the previous frame's, both on onset and on clearing.
- R6: Bit 2 of `status` sets when a frame strobe arrives with `bip_err` at 1.
- R7: Bit 1 of `status` sets when a frame strobe arrives with `fa1_byte` not equal to FA1_PAT (default 8'hF6) or `fa2_byte` not equal to FA2_PAT (default 8'h28).
- R8: Bit 0 of `status` sets when the frame's `pt_bits` differ from those of the previous frame.
- R9: A set status bit stays 1 until a cycle with `rd_stb` high; the edge after that cycle clears every bit that has no new event.
- R10: An event present in the same cycle as `rd_stb` leaves its bit at 1 after the read.
- R11: The first frame after reset loads the payload type and failure history and raises neither bit 0 nor bit 3.
- R12: `irq` is 1 exactly when some status bit is 1 together with the same bit of `int_en`; status bits record events whatever `int_en` holds.
- R13: Without a frame strobe, the overhead inputs change neither `status` nor the payload type and failure history; bit 7 of `status` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_stb | input | 1 | Frame boundary strobe; overhead inputs are valid in this cycle |
| fa1_byte | input | 8 | First framing byte of the frame |
| fa2_byte | input | 8 | Second framing byte of the frame |
| bip_err | input | 1 | Parity check judged the frame errored |
| x_bits | input | XB_W | Far-end failure bits; condition holds when all are 0 |
| febe_bit | input | 1 | Far-end block error indication |
| pt_bits | input | PT_W | Payload type field |
| tr_byte | input | 8 | Trail trace byte |
| lapd_done | input | 1 | Data-link message receiver finished a message (any cycle) |
| rd_stb | input | 1 | Status register read; clears status at the next edge |
| int_en | input | 8 | Per-bit interrupt enable mask |
| status | output | 8 | Sticky status word |
| irq | output | 1 | Combined interrupt line |

## Verification
The hardest situation is the cross-frame behaviour right after reset: the first frame must prime the history without raising a change, and only later frames may set bits 0 and 3. The stimulus opens with a first frame that carries both a non-default payload type and an active failure condition, then walks the condition off and on again across frames with reads between them. It also presents overhead changes without a strobe and follows with a frame matching the last latched values, which shows at the status port that the history was not disturbed. Reads coinciding with events confirm that no event is lost to a clear.

// File: rtl/e3ovh_pkg.sv
package e3ovh_pkg;

    localparam int STAT_W = 8;

    // Status bit layout, MSB first so the packed struct maps onto status[7:0].
    typedef struct packed {
        logic rsv;       // bit 7, always 0
        logic trc_start; // bit 6
        logic msg_done;  // bit 5
        logic febe;      // bit 4
        logic ferf_chg;  // bit 3
        logic bip;       // bit 2
        logic fa_err;    // bit 1
        logic pt_chg;    // bit 0
    } evt_t;

    function automatic logic all_zero(input logic [31:0] v, input int w);
        logic z;
        z = 1'b1;
        for (int i = 0; i < 32; i++) begin
            if (i < w && v[i]) z = 1'b0;
        end
        return z;
    endfunction

endpackage

// File: rtl/e3ovh_event_detect.sv
module e3ovh_event_detect
    import e3ovh_pkg::*;
#(
    parameter int PT_W = 3,
    parameter int XB_W = 2,
    parameter logic [7:0] FA1_PAT = 8'hF6,
    parameter logic [7:0] FA2_PAT = 8'h28
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frm_stb,
    input  logic [7:0]      fa1_byte,
    input  logic [7:0]      fa2_byte,
    input  logic            bip_err,
    input  logic [XB_W-1:0] x_bits,
    input  logic            febe_bit,
    input  logic [PT_W-1:0] pt_bits,
    input  logic [7:0]      tr_byte,
    input  logic            lapd_done,
    output evt_t            evt
);

    localparam int XPAD = 32 - XB_W;

    logic [PT_W-1:0] pt_hist;
    logic            ferf_hist;
    logic            hist_ok;
    logic            ferf_now;

    assign ferf_now = all_zero({{XPAD{1'b0}}, x_bits}, XB_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            pt_hist   <= '0;
            ferf_hist <= 1'b0;
            hist_ok   <= 1'b0;
        end else if (frm_stb) begin
            pt_hist   <= pt_bits;
            ferf_hist <= ferf_now;
            hist_ok   <= 1'b1;
        end
    end

    always_comb begin
        evt          = '0;
        evt.msg_done = lapd_done;
        if (frm_stb) begin
            evt.trc_start = tr_byte[7];
            evt.febe      = febe_bit;
            evt.bip       = bip_err;
            evt.fa_err    = (fa1_byte != FA1_PAT) || (fa2_byte != FA2_PAT);
            evt.pt_chg    = hist_ok && (pt_bits != pt_hist);
            evt.ferf_chg  = hist_ok && (ferf_now != ferf_hist);
        end
    end

endmodule

// File: rtl/e3ovh_sticky_bank.sv
module e3ovh_sticky_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= (q[i] && !clr) || set[i];
        end
    end

endmodule

// File: rtl/e3ovh_irq_reg.sv
module e3ovh_irq_reg
    import e3ovh_pkg::*;
#(
    parameter int PT_W = 3,
    parameter int XB_W = 2,
    parameter logic [7:0] FA1_PAT = 8'hF6,
    parameter logic [7:0] FA2_PAT = 8'h28
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frm_stb,
    input  logic [7:0]      fa1_byte,
    input  logic [7:0]      fa2_byte,
    input  logic            bip_err,
    input  logic [XB_W-1:0] x_bits,
    input  logic            febe_bit,
    input  logic [PT_W-1:0] pt_bits,
    input  logic [7:0]      tr_byte,
    input  logic            lapd_done,
    input  logic            rd_stb,
    input  logic [7:0]      int_en,
    output logic [7:0]      status,
    output logic            irq
);

    evt_t              evt;
    logic [STAT_W-1:0] st_q;

    e3ovh_event_detect #(
        .PT_W(PT_W), .XB_W(XB_W), .FA1_PAT(FA1_PAT), .FA2_PAT(FA2_PAT)
    ) u_detect (
        .clk(clk), .rst(rst), .frm_stb(frm_stb),
        .fa1_byte(fa1_byte), .fa2_byte(fa2_byte), .bip_err(bip_err),
        .x_bits(x_bits), .febe_bit(febe_bit), .pt_bits(pt_bits),
        .tr_byte(tr_byte), .lapd_done(lapd_done), .evt(evt)
    );

    e3ovh_sticky_bank #(.W(STAT_W)) u_bank (
        .clk(clk), .rst(rst), .clr(rd_stb), .set(evt), .q(st_q)
    );

    assign status = st_q;
    assign irq    = |(st_q & int_en);

endmodule

// File: rtl/e3ovh_irq_chk.sv
module e3ovh_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       frm_stb,
    input logic       bip_err,
    input logic       febe_bit,
    input logic [7:0] tr_byte,
    input logic       lapd_done,
    input logic       rd_stb,
    input logic [7:0] status
);

    logic seen_frame;

    always_ff @(posedge clk) begin
        if (rst)          seen_frame <= 1'b0;
        else if (frm_stb) seen_frame <= 1'b1;
    end

    p_trc_r2: assert property (@(posedge clk) disable iff (rst)
        frm_stb && tr_byte[7] |=> status[6]);

    p_msg_r3: assert property (@(posedge clk) disable iff (rst)
        lapd_done |=> status[5]);

    p_febe_r4: assert property (@(posedge clk) disable iff (rst)
        frm_stb && febe_bit |=> status[4]);

    p_bip_r6: assert property (@(posedge clk) disable iff (rst)
        frm_stb && bip_err |=> status[2]);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> ((status & $past(status)) == $past(status)));

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        rd_stb && !frm_stb && !lapd_done |=> (status == 8'h00));

    p_first_r11: assert property (@(posedge clk) disable iff (rst)
        frm_stb && !seen_frame |=> !status[0] && !status[3]);

    p_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        !frm_stb && !lapd_done && !rd_stb |=> $stable(status));

endmodule

bind e3ovh_irq_reg e3ovh_irq_chk u_chk (
    .clk(clk), .rst(rst), .frm_stb(frm_stb), .bip_err(bip_err),
    .febe_bit(febe_bit), .tr_byte(tr_byte), .lapd_done(lapd_done),
    .rd_stb(rd_stb), .status(status)
);

// File: tb/e3ovh_irq_reg_test.sv
`timescale 1ns/1ps
module e3ovh_irq_reg_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frm_stb = 1'b0;
    logic [7:0] fa1_byte = 8'hF6;
    logic [7:0] fa2_byte = 8'h28;
    logic       bip_err = 1'b0;
    logic [1:0] x_bits = 2'b11;
    logic       febe_bit = 1'b0;
    logic [2:0] pt_bits = 3'd2;
    logic [7:0] tr_byte = 8'h00;
    logic       lapd_done = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] int_en = 8'h00;
    logic [7:0] status;
    logic       irq;

    always #4 clk = ~clk;

    e3ovh_irq_reg uut (
        .clk(clk), .rst(rst), .frm_stb(frm_stb), .fa1_byte(fa1_byte),
        .fa2_byte(fa2_byte), .bip_err(bip_err), .x_bits(x_bits),
        .febe_bit(febe_bit), .pt_bits(pt_bits), .tr_byte(tr_byte),
        .lapd_done(lapd_done), .rd_stb(rd_stb), .int_en(int_en),
        .status(status), .irq(irq)
    );

    typedef struct {
        logic [7:0] st;
        logic       irq;
        string      tag;
    } sb_item_t;

    sb_item_t sb[$];
    sb_item_t got;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench-side model state
    logic [7:0] m_st = 8'h00;
    logic [2:0] m_pt = 3'd0;
    logic       m_ferf = 1'b0;
    logic       m_ok = 1'b0;

    // Stimulus values for the next cycle
    logic       n_f, n_b, n_fb, n_ld, n_rd;
    logic [7:0] n_a1, n_a2, n_tr, n_en;
    logic [1:0] n_x;
    logic [2:0] n_pt;

    task automatic dflt();
        n_f = 0; n_b = 0; n_fb = 0; n_ld = 0; n_rd = 0;
        n_a1 = 8'hF6; n_a2 = 8'h28; n_tr = 8'h00; n_x = 2'b11; n_pt = m_pt;
    endtask

    task automatic step(input string tag);
        logic [7:0] evt;
        sb_item_t it;
        @(negedge clk);
        frm_stb = n_f; fa1_byte = n_a1; fa2_byte = n_a2; bip_err = n_b;
        x_bits = n_x; febe_bit = n_fb; pt_bits = n_pt; tr_byte = n_tr;
        lapd_done = n_ld; rd_stb = n_rd; int_en = n_en;
        evt = 8'h00;
        if (n_f) begin
            evt[6] = n_tr[7];
            evt[4] = n_fb;
            evt[2] = n_b;
            evt[1] = (n_a1 != 8'hF6) || (n_a2 != 8'h28);
            if (m_ok) begin
                evt[0] = (n_pt != m_pt);
                evt[3] = ((n_x == 2'b00) != m_ferf);
            end
            m_pt = n_pt; m_ferf = (n_x == 2'b00); m_ok = 1'b1;
        end
        if (n_ld) evt[5] = 1'b1;
        m_st = (n_rd ? 8'h00 : m_st) | evt;
        it.st = m_st; it.irq = |(m_st & n_en); it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: samples 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            got = sb.pop_front();
            checks++;
            if (status !== got.st || irq !== got.irq) begin
                errors++;
                $display("FAIL %s status=%h irq=%b expected status=%h irq=%b",
                         got.tag, status, irq, got.st, got.irq);
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        n_en = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (status !== 8'h00 || irq !== 1'b0) begin
            errors++;
            $display("FAIL R1 status=%h irq=%b expected status=00 irq=0", status, irq);
        end

        // R11: first frame with a new payload type and failure active
        dflt(); n_f = 1; n_pt = 3'd5; n_x = 2'b00; step("R11");
        dflt(); step("R11");
        // steady frame: same type, failure still active
        dflt(); n_f = 1; n_pt = 3'd5; n_x = 2'b00; step("R8");
        // R8: payload type change
        dflt(); n_f = 1; n_pt = 3'd6; n_x = 2'b00; step("R8");
        dflt(); step("R9");
        dflt(); step("R9");
        dflt(); n_rd = 1; step("R9");
        // R5: failure clears, then returns
        dflt(); n_f = 1; n_x = 2'b01; step("R5");
        dflt(); n_rd = 1; step("R9");
        dflt(); n_f = 1; n_x = 2'b10; step("R5");
        dflt(); n_f = 1; n_x = 2'b00; step("R5");
        dflt(); n_rd = 1; step("R9");
        // R4, R6, R7
        dflt(); n_f = 1; n_x = 2'b00; n_fb = 1; step("R4");
        dflt(); n_rd = 1; step("R9");
        dflt(); n_f = 1; n_x = 2'b00; n_b = 1; step("R6");
        dflt(); n_rd = 1; step("R9");
        dflt(); n_f = 1; n_x = 2'b00; n_a1 = 8'hF7; step("R7");
        dflt(); n_rd = 1; step("R9");
        dflt(); n_f = 1; n_x = 2'b00; n_a2 = 8'h29; step("R7");
        dflt(); n_rd = 1; step("R9");
        // R2
        dflt(); n_f = 1; n_x = 2'b00; n_tr = 8'h7F; step("R2");
        dflt(); n_f = 1; n_x = 2'b00; n_tr = 8'h80; step("R2");
        dflt(); n_rd = 1; step("R9");
        // R3: message pulse without a frame strobe
        dflt(); n_ld = 1; step("R3");
        dflt(); n_rd = 1; step("R9");
        // R13: overhead activity without strobe
        dflt(); n_fb = 1; n_b = 1; n_tr = 8'hFF; n_a1 = 8'h00;
        n_pt = 3'd1; n_x = 2'b11; step("R13");
        dflt(); n_fb = 1; n_pt = 3'd3; step("R13");
        // frame matching the last latched type and failure: no change events
        dflt(); n_f = 1; n_pt = 3'd6; n_x = 2'b00; step("R13");
        // R10: events coinciding with a read
        dflt(); n_ld = 1; step("R10");
        dflt(); n_f = 1; n_x = 2'b00; n_fb = 1; n_rd = 1; step("R10");
        dflt(); n_ld = 1; n_rd = 1; step("R10");
        dflt(); n_rd = 1; step("R10");
        // R12: enable mask gates only the line
        n_en = 8'h10;
        dflt(); n_f = 1; n_x = 2'b00; n_b = 1; step("R12");
        n_en = 8'h04;
        dflt(); step("R12");
        n_en = 8'hFB;
        dflt(); step("R12");
        n_en = 8'h00;
        dflt(); n_rd = 1; step("R12");

        @(negedge clk);
        @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left %0d items expected 0", sb.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule